// File: doc/BRIEF.md
# Register-Pair Stack Transfer Sequencer

This block is a small multi-cycle controller that moves 16-bit register pairs between a register file and a byte-wide memory. It holds four byte pairs and a 16-bit stack pointer (SP). The pairs are a general pair (B/C), a second pair (D/E), the address pair (H/L) and an accumulator/flags pair (A/F). A command starts one operation, and the sequencer then runs its byte accesses one per cycle over a single-port synchronous memory. The operations are a stack push, a stack pop, a swap of H/L with the two bytes on top of the stack, a direct 16-bit load or store of H/L at an operand address, a swap of H/L with D/E, and a copy of H/L into SP.

The surrounding core decodes instructions and presents an operation code, a pair select and an address operand together with a one-cycle `start`. The memory returns read data one cycle after the address is presented. `done` pulses in the last cycle of every operation. The register file is visible only through the memory port. To inspect it, software stores or pushes a pair and reads the memory.

Top module: `pair_stack_seq`

## Requirements
- R1: A synchronous active-high reset clears all eight pair bytes and SP to zero, and `done` is low after reset.
- R2: Push (opCode 0) first decrements SP. It then writes the high byte of the selected pair at the new SP, decrements SP again and writes the low byte there. SP ends two lower than it started, and `done` comes in the second cycle after the start cycle.
- R3: Pair select codes are 0 = B/C, 1 = D/E, 2 = H/L and 3 = A/F. For code 3 the accumulator is the high byte and the flags register is the low byte.
- R4: Pop (opCode 1) loads the low byte from memory[SP] and the high byte from memory[SP+1], and leaves SP two higher. `done` comes in the third cycle after the start cycle.
- R5: Exchange with stack top (opCode 2) swaps L with memory[SP] and H with memory[SP+1]. It writes H's old value at SP+1 first, then L's old value at SP. SP is unchanged, and `done` comes in the fourth cycle.
- R6: Direct load (opCode 3) sets L from memory[addrOp] and H from memory[addrOp+1], with `done` in the third cycle. Direct store (opCode 4) writes L at addrOp and H at addrOp+1, with `done` in the second cycle, and leaves H/L unchanged.
- R7: opCode 5 swaps D with H and E with L. opCode 6 loads SP with H as its high byte and L as its low byte. Each finishes with `done` in the first cycle after the start cycle.
- R8: `done` is high for exactly one cycle per operation.
- R9: A `start` that arrives while an operation is in progress is ignored and launches nothing.
- R10: SP and the direct-transfer address wrap modulo 65536: decrementing 0x0000 gives 0xFFFF, and the byte after 0xFFFF is at 0x0000.
- R11: opCode 7 changes no register and no memory, and completes with `done` in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one operation when idle |
| opCode | input | 3 | Operation code (see R2 to R11) |
| pairSel | input | 2 | Pair select for push and pop (see R3) |
| addrOp | input | 16 | Address operand for direct load and store |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 8 | Memory read data, valid one cycle after its address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the stack-top exchange. It has to be shown that SP did not move and that both old H/L bytes and both old stack bytes ended up in the right places. The register file is not visible directly, so the bench first builds known pair contents by popping preloaded stack bytes. After the exchange it takes H/L out with a direct store and takes SP out with a push, whose first write address is SP minus one. The ignored-start case is reached by holding `start` high with a different operation code during the second cycle of a push.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int NUM_PAIRS = 4;
  localparam int PAIR_W    = $clog2(NUM_PAIRS);
  localparam int PAIR_DE   = 1;
  localparam int PAIR_HL   = 2;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_XTOP  = 3'd2,
    OP_LDHL  = 3'd3,
    OP_STHL  = 3'd4,
    OP_XDE   = 3'd5,
    OP_HL2SP = 3'd6,
    OP_NONE  = 3'd7
  } opcode_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic              ptrLoadOp;
    logic              ptrLoadSp;
    logic              ptrInc;
    logic              ptrDec;
    logic              spInc;
    logic              spDec;
    logic              spLoadHl;
    logic              addrFromSp;
    logic              memWe;
    logic              writeHi;
    logic              loadLo;
    logic              loadHi;
    logic              loadLoTmp;
    logic              tmpLoad;
    logic              swapDeHl;
    logic [PAIR_W-1:0] pair;
  } strobe_t;

endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        opCode,
  input  logic [PAIR_W-1:0] pairSel,
  output strobe_t           strb,
  output logic              done
);

  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_HI, S_PUSH_LO, S_POP_LO, S_POP_HI, S_POP_FIN,
    S_XT_RD_LO, S_XT_RD_HI, S_XT_WR_HI, S_XT_WR_LO,
    S_LD_LO, S_LD_HI, S_LD_FIN, S_ST_LO, S_ST_HI, S_ONE
  } state_e;

  state_e            state, nextState;
  opcode_e           curOp, inOp;
  logic [PAIR_W-1:0] curPair;
  logic              busy;

  assign inOp = opcode_e'(opCode);
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      curOp   <= OP_NONE;
      curPair <= '0;
    end else begin
      state <= nextState;
      if (!busy && start) begin
        curOp <= inOp;
        if (inOp == OP_XTOP || inOp == OP_LDHL || inOp == OP_STHL)
          curPair <= PAIR_W'(PAIR_HL);
        else
          curPair <= pairSel;
      end
    end
  end

  always_comb begin
    strb      = '0;
    strb.pair = curPair;
    done      = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          unique case (inOp)
            OP_PUSH: begin strb.spDec = 1'b1;     nextState = S_PUSH_HI;  end
            OP_POP:  begin                        nextState = S_POP_LO;   end
            OP_XTOP: begin strb.ptrLoadSp = 1'b1; nextState = S_XT_RD_LO; end
            OP_LDHL: begin strb.ptrLoadOp = 1'b1; nextState = S_LD_LO;    end
            OP_STHL: begin strb.ptrLoadOp = 1'b1; nextState = S_ST_LO;    end
            default: nextState = S_ONE;
          endcase
        end
      end
      S_PUSH_HI: begin
        strb.addrFromSp = 1'b1; strb.memWe = 1'b1; strb.writeHi = 1'b1;
        strb.spDec = 1'b1; nextState = S_PUSH_LO;
      end
      S_PUSH_LO: begin
        strb.addrFromSp = 1'b1; strb.memWe = 1'b1; done = 1'b1;
        nextState = S_IDLE;
      end
      S_POP_LO: begin
        strb.addrFromSp = 1'b1; strb.spInc = 1'b1; nextState = S_POP_HI;
      end
      S_POP_HI: begin
        strb.addrFromSp = 1'b1; strb.spInc = 1'b1; strb.loadLo = 1'b1;
        nextState = S_POP_FIN;
      end
      S_POP_FIN: begin
        strb.loadHi = 1'b1; done = 1'b1; nextState = S_IDLE;
      end
      S_XT_RD_LO: begin strb.ptrInc = 1'b1; nextState = S_XT_RD_HI; end
      S_XT_RD_HI: begin strb.tmpLoad = 1'b1; nextState = S_XT_WR_HI; end
      S_XT_WR_HI: begin
        strb.memWe = 1'b1; strb.writeHi = 1'b1; strb.loadHi = 1'b1;
        strb.ptrDec = 1'b1; nextState = S_XT_WR_LO;
      end
      S_XT_WR_LO: begin
        strb.memWe = 1'b1; strb.loadLoTmp = 1'b1; done = 1'b1;
        nextState = S_IDLE;
      end
      S_LD_LO:  begin strb.ptrInc = 1'b1; nextState = S_LD_HI; end
      S_LD_HI:  begin strb.loadLo = 1'b1; nextState = S_LD_FIN; end
      S_LD_FIN: begin strb.loadHi = 1'b1; done = 1'b1; nextState = S_IDLE; end
      S_ST_LO:  begin strb.memWe = 1'b1; strb.ptrInc = 1'b1; nextState = S_ST_HI; end
      S_ST_HI: begin
        strb.memWe = 1'b1; strb.writeHi = 1'b1; done = 1'b1;
        nextState = S_IDLE;
      end
      S_ONE: begin
        strb.swapDeHl = (curOp == OP_XDE);
        strb.spLoadHl = (curOp == OP_HL2SP);
        done = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(curOp) && $stable(curPair))); // R9

endmodule

// File: rtl/pss_dpath.sv
module pss_dpath
  import pss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [2*DATA_W-1:0]   addrOp,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic                  memWe
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] hiBus [NUM_PAIRS];
  logic [DATA_W-1:0] loBus [NUM_PAIRS];
  logic [ADDR_W-1:0] sp, ptr;
  logic [DATA_W-1:0] tmp;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam int PARTNER = PAIR_DE + PAIR_HL - g;
    localparam bit SWAPS   = (g == PAIR_DE) || (g == PAIR_HL);
    logic [DATA_W-1:0] hiQ, loQ;
    logic              sel;
    assign sel      = (strb.pair == PAIR_W'(g));
    assign hiBus[g] = hiQ;
    assign loBus[g] = loQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        hiQ <= '0;
        loQ <= '0;
      end else begin
        if (SWAPS && strb.swapDeHl) begin
          hiQ <= hiBus[PARTNER];
          loQ <= loBus[PARTNER];
        end
        if (sel && strb.loadHi)    hiQ <= memRdata;
        if (sel && strb.loadLo)    loQ <= memRdata;
        if (sel && strb.loadLoTmp) loQ <= tmp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ptr <= '0;
      tmp <= '0;
    end else begin
      if (strb.spDec)         sp <= sp - 1'b1;
      else if (strb.spInc)    sp <= sp + 1'b1;
      else if (strb.spLoadHl) sp <= {hiBus[PAIR_HL], loBus[PAIR_HL]};
      if (strb.ptrLoadOp)      ptr <= addrOp;
      else if (strb.ptrLoadSp) ptr <= sp;
      else if (strb.ptrInc)    ptr <= ptr + 1'b1;
      else if (strb.ptrDec)    ptr <= ptr - 1'b1;
      if (strb.tmpLoad) tmp <= memRdata;
    end
  end

  assign memAddr  = strb.addrFromSp ? sp : ptr;
  assign memWdata = strb.writeHi ? hiBus[strb.pair] : loBus[strb.pair];
  assign memWe    = strb.memWe;

  AST_SP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strb.spDec && sp == '0) |=> (sp == '1)); // R10

  AST_SP_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (strb.spInc && !strb.spDec && sp == '1) |=> (sp == '0)); // R10

endmodule

// File: rtl/pair_stack_seq.sv
module pair_stack_seq
  import pss_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        opCode,
  input  logic [PAIR_W-1:0] pairSel,
  input  logic [ADDR_W-1:0] addrOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done
);

  strobe_t strb;

  pss_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opCode  (opCode),
    .pairSel (pairSel),
    .strb    (strb),
    .done    (done)
  );

  pss_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .addrOp   (addrOp),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe)
  );

endmodule

// File: tb/sim_pair_stack_seq.sv
`timescale 1ns/1ps
module sim_pair_stack_seq;

  localparam logic [2:0] PUSH = 3'd0, POP = 3'd1, XTOP = 3'd2, LDHL = 3'd3,
                         STHL = 3'd4, XDE = 3'd5, HL2SP = 3'd6, NOP7 = 3'd7;
  localparam logic [1:0] P_BC = 2'd0, P_DE = 2'd1, P_AF = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  pairSel = '0;
  logic [15:0] addrOp = '0;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [7:0]  memRdata;
  logic        done;

  logic [7:0]  mem [256];
  logic        pokeEn = 1'b0;
  logic [7:0]  pokeAddr = '0;
  logic [7:0]  pokeData = '0;
  logic [15:0] wrA [64];
  logic [7:0]  wrD [64];
  int          wrCnt = 0;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  pair_stack_seq u0 (
    .clk(clk), .rst(rst), .start(start), .opCode(opCode), .pairSel(pairSel),
    .addrOp(addrOp), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .done(done)
  );

  // Byte memory model: one-cycle read latency, write log with full address
  always @(posedge clk) begin
    if (pokeEn) mem[pokeAddr] <= pokeData;
    else if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      wrA[wrCnt % 64] <= memAddr;
      wrD[wrCnt % 64] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
    memRdata <= mem[memAddr[7:0]];
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic poke(logic [7:0] a, logic [7:0] d);
    @(negedge clk); pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic runOp(logic [2:0] op, logic [1:0] pr, logic [15:0] a,
                       int expLat, string tag);
    int lat;
    @(negedge clk);
    start = 1'b1; opCode = op; pairSel = pr; addrOp = a;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk(tag, "latency", lat, expLat);
    @(negedge clk);
    chk("R8", "done after pulse", done, 0);
  endtask

  task automatic pushCheck(logic [1:0] pr, logic [7:0] hi, logic [7:0] lo,
                           logic [15:0] spBefore, string tag);
    int b = wrCnt;
    logic [15:0] a1 = spBefore - 16'd1;
    logic [15:0] a2 = spBefore - 16'd2;
    runOp(PUSH, pr, 16'h0, 2, tag);
    chk(tag, "push write count", wrCnt - b, 2);
    chk(tag, "push addr hi", wrA[b % 64], a1);
    chk(tag, "push data hi", wrD[b % 64], hi);
    chk(tag, "push addr lo", wrA[(b + 1) % 64], a2);
    chk(tag, "push data lo", wrD[(b + 1) % 64], lo);
  endtask

  task automatic popPair(logic [1:0] pr);
    runOp(POP, pr, 16'h0, 3, "R4");
  endtask

  task automatic storeCheck(logic [15:0] a, logic [7:0] h, logic [7:0] l, string tag);
    int b = wrCnt;
    logic [15:0] a1 = a + 16'd1;
    runOp(STHL, 2'd0, a, 2, tag);
    chk(tag, "store count", wrCnt - b, 2);
    chk(tag, "store addr L", wrA[b % 64], a);
    chk(tag, "store addr H", wrA[(b + 1) % 64], a1);
    chk(tag, "stored L", mem[a[7:0]], l);
    chk(tag, "stored H", mem[a1[7:0]], h);
  endtask

  task automatic t_reset();
    chk("R1", "done in reset", done, 0);
    // zero pair and zero SP: push wraps to 0xFFFF (R10)
    pushCheck(P_AF, 8'h00, 8'h00, 16'h0000, "R1");
    popPair(P_AF);
  endtask

  task automatic t_pop_push();
    poke(8'h20, 8'h40); poke(8'h21, 8'h00);
    runOp(LDHL, 2'd0, 16'h0020, 3, "R6");
    runOp(HL2SP, 2'd0, 16'h0, 1, "R7");
    poke(8'h40, 8'hC1); poke(8'h41, 8'hB1);
    poke(8'h42, 8'hE2); poke(8'h43, 8'hD2);
    poke(8'h44, 8'hF3); poke(8'h45, 8'hA3);
    popPair(P_BC); popPair(P_DE); popPair(P_AF);
    pushCheck(P_AF, 8'hA3, 8'hF3, 16'h0046, "R3");
    pushCheck(P_DE, 8'hD2, 8'hE2, 16'h0044, "R2");
    pushCheck(P_BC, 8'hB1, 8'hC1, 16'h0042, "R4");
  endtask

  task automatic t_store();
    storeCheck(16'h0080, 8'h00, 8'h40, "R6");
    storeCheck(16'h0090, 8'h00, 8'h40, "R6");
  endtask

  task automatic t_xde();
    runOp(XDE, 2'd0, 16'h0, 1, "R7");
    storeCheck(16'h0080, 8'hD2, 8'hE2, "R7");
    pushCheck(P_DE, 8'h00, 8'h40, 16'h0040, "R7");
    popPair(P_DE);
  endtask

  task automatic t_xtop();
    int b = wrCnt;
    runOp(XTOP, 2'd0, 16'h0, 4, "R5");
    chk("R5", "xt write count", wrCnt - b, 2);
    chk("R5", "xt first addr", wrA[b % 64], 16'h0041);
    chk("R5", "xt first data", wrD[b % 64], 8'hD2);
    chk("R5", "xt second addr", wrA[(b + 1) % 64], 16'h0040);
    chk("R5", "xt second data", wrD[(b + 1) % 64], 8'hE2);
    storeCheck(16'h0080, 8'hB1, 8'hC1, "R5");
    pushCheck(P_BC, 8'hB1, 8'hC1, 16'h0040, "R5");
    popPair(P_BC);
  endtask

  task automatic t_busy_start();
    int b = wrCnt;
    @(negedge clk); start = 1'b1; opCode = PUSH; pairSel = P_AF;
    @(negedge clk); opCode = XDE;           // held during busy: must be ignored
    @(negedge clk); start = 1'b0;
    chk("R9", "done of push", done, 1);
    @(negedge clk);
    chk("R9", "done after", done, 0);
    repeat (3) @(negedge clk);
    chk("R9", "write count", wrCnt - b, 2);
    chk("R9", "push hi addr", wrA[b % 64], 16'h003F);
    storeCheck(16'h0080, 8'hB1, 8'hC1, "R9");
    popPair(P_AF);
  endtask

  task automatic t_reserved();
    int b = wrCnt;
    runOp(NOP7, 2'd2, 16'h1234, 1, "R11");
    chk("R11", "no writes", wrCnt - b, 0);
    storeCheck(16'h0080, 8'hB1, 8'hC1, "R11");
    pushCheck(P_AF, 8'hA3, 8'hF3, 16'h0040, "R11");
    popPair(P_AF);
  endtask

  task automatic t_wrap();
    poke(8'hFF, 8'h5A); poke(8'h00, 8'hA5);
    runOp(LDHL, 2'd0, 16'hFFFF, 3, "R10");
    storeCheck(16'h0080, 8'hA5, 8'h5A, "R10");
    storeCheck(16'hFFFF, 8'hA5, 8'h5A, "R10");
  endtask

  task automatic t_hl2sp();
    runOp(HL2SP, 2'd0, 16'h0, 1, "R7");
    pushCheck(P_BC, 8'hB1, 8'hC1, 16'hA55A, "R7");
    popPair(P_BC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pop_push();
    t_store();
    t_xde();
    t_xtop();
    t_busy_start();
    t_reserved();
    t_wrap();
    t_hl2sp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule